// File: doc/BRIEF.md
# Descriptor Ring Occupancy Tracker

This block keeps the bookkeeping for a circular queue of work descriptors that a host fills and a processing engine drains. The host programs the ring length and the descriptor size, can halt or run the engine, announces how many new descriptors it has written, and later hands back a count of completed descriptors it has finished with. Each descriptor therefore moves through three states: posted (waiting for the engine), completed but not yet released, and free again.

The block offers the engine the index of the next descriptor to fetch through a valid/ready pair. A one-cycle completion pulse from the engine marks the oldest fetched descriptor as done. A status word gives the host the number of completed descriptors awaiting release and the index of the oldest of them. Descriptor memory traffic and the data work itself are outside this block.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset the engine is halted, `fetch_valid` is 0, `done_status` is 0, `desc_bytes` is 32 and `rel_err` is 0. The ring length resets to 16 entries.
- R2: A write with `wr_sel`=3 adds `wr_data[14:0]` to the posted count. `fetch_valid` is high exactly when the engine runs and the posted count is nonzero.
- R3: A write with `wr_sel`=2 sets `halted` to `wr_data[0]`. While halted, `fetch_valid` stays low, but post and release writes are still taken.
- R4: Each accepted fetch (`fetch_valid` and `fetch_ready`) lowers the posted count by one and moves `fetch_idx` forward by one. `fetch_idx` goes back to 0 after the last entry of the ring.
- R5: An `eng_done` pulse while at least one fetched descriptor is unfinished raises the pending count in `done_status[14:0]` by one. When nothing is in flight, the pulse is ignored.
- R6: A write with `wr_sel`=4 lowers the pending count by `wr_data[14:0]`. It moves the read index in `done_status[29:16]` forward by the same amount, modulo the ring length.
- R7: A release larger than the pending count is clamped to the pending count and sets `rel_err`. `rel_err` stays set until reset.
- R8: A write with `wr_sel`=1 and value 1 selects 32-byte descriptors, and value 7 selects 128-byte descriptors. Any other value is ignored. `desc_bytes` shows the current size.
- R9: A write with `wr_sel`=0 sets the ring length. A value of 0, or one above the limit for the current descriptor size (16384 for 32-byte, 4096 for 128-byte), is ignored. The ring length in use never exceeds that limit.
- R10: A completion and a release in the same cycle both take effect on the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 length, 1 size, 2 halt, 3 post, 4 release |
| wr_data | input | 32 | Write value |
| fetch_valid | output | 1 | A posted descriptor is offered to the engine |
| fetch_ready | input | 1 | Engine takes the offered descriptor |
| fetch_idx | output | 14 | Ring index of the offered descriptor |
| desc_bytes | output | 8 | Descriptor size in bytes (32 or 128) |
| eng_done | input | 1 | Engine finished its oldest fetched descriptor |
| done_status | output | 32 | Pending count in [14:0], read index in [29:16] |
| halted | output | 1 | Engine is stopped |
| rel_err | output | 1 | Sticky flag for an over-sized release |

## Verification
Every write, fetch and completion shows up on the outputs one clock edge after the cycle in which it is presented. All state is registered, and the outputs are plain decodes of that state. The bench drives its inputs on the falling edge and steps a behavioural model on the rising edge. On the next falling edge it compares every output against that model, so each comparison lands exactly one edge after the stimulus. Directed checks for reset, clamping, size selection and simultaneous completion and release are sampled at that same point.

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker #(
  parameter int PTR_W       = 14,
  parameter int CNT_W       = 15,
  parameter int RST_ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [PTR_W-1:0] fetch_idx,
  output logic [7:0]       desc_bytes,
  input  logic             eng_done,
  output logic [31:0]      done_status,
  output logic             halted,
  output logic             rel_err
);
  localparam int ENT_W = PTR_W + 1;
  localparam int SW    = CNT_W + 1;
  localparam logic [ENT_W-1:0] LIM_S = ENT_W'(1) << PTR_W;
  localparam logic [ENT_W-1:0] LIM_B = ENT_W'(1) << (PTR_W - 2);

  logic [ENT_W-1:0] qsize;
  logic             big;
  logic [CNT_W:0]   posted;
  logic [CNT_W-1:0] inflight, pend;
  logic [PTR_W-1:0] fptr, rptr;

  logic [ENT_W-1:0] cap, eff;
  assign cap = big ? LIM_B : LIM_S;
  assign eff = (qsize > cap) ? cap : qsize;

  logic w_size, w_dsz, w_halt, w_add, w_rel;
  assign w_size = wr_en && wr_sel == 3'd0;
  assign w_dsz  = wr_en && wr_sel == 3'd1;
  assign w_halt = wr_en && wr_sel == 3'd2;
  assign w_add  = wr_en && wr_sel == 3'd3;
  assign w_rel  = wr_en && wr_sel == 3'd4;

  logic [CNT_W-1:0] req, rel_amt;
  logic             over, take, fin;
  assign req     = wr_data[CNT_W-1:0];
  assign over    = w_rel && (req > pend);
  assign rel_amt = !w_rel ? '0 : (over ? pend : req);
  assign take    = fetch_valid && fetch_ready;
  assign fin     = eng_done && (inflight != '0);

  logic [SW-1:0]    rsum;
  logic [PTR_W-1:0] rnext, fnext;
  logic [ENT_W-1:0] new_size;
  logic             size_ok;
  assign rsum     = SW'(rptr) + SW'(rel_amt);
  assign rnext    = (rsum >= SW'(eff)) ? PTR_W'(rsum - SW'(eff)) : PTR_W'(rsum);
  assign fnext    = (ENT_W'(fptr) + ENT_W'(1) >= eff) ? '0 : fptr + PTR_W'(1);
  assign new_size = (wr_data[31:ENT_W] == '0) ? wr_data[ENT_W-1:0] : '0;
  assign size_ok  = (new_size != '0) && (new_size <= cap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qsize    <= ENT_W'(RST_ENTRIES);
      big      <= 1'b0;
      halted   <= 1'b1;
      posted   <= '0;
      inflight <= '0;
      pend     <= '0;
      fptr     <= '0;
      rptr     <= '0;
      rel_err  <= 1'b0;
    end else begin
      if (w_size && size_ok) qsize <= new_size;
      if (w_dsz && wr_data == 32'd1) big <= 1'b0;
      if (w_dsz && wr_data == 32'd7) big <= 1'b1;
      if (w_halt) halted <= wr_data[0];
      if (over) rel_err <= 1'b1;
      posted   <= posted + (w_add ? {1'b0, req} : '0) - SW'(take);
      inflight <= inflight + CNT_W'(take) - CNT_W'(fin);
      pend     <= pend + CNT_W'(fin) - rel_amt;
      rptr     <= rnext;
      if (take) fptr <= fnext;
    end
  end

  assign fetch_valid = !halted && (posted != '0);
  assign fetch_idx   = fptr;
  assign desc_bytes  = big ? 8'd128 : 8'd32;

  always_comb begin
    done_status              = '0;
    done_status[CNT_W-1:0]   = pend;
    done_status[16 +: PTR_W] = rptr;
  end
endmodule

// File: rtl/desc_ring_tracker_chk.sv
module desc_ring_tracker_chk #(
  parameter int PTR_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic [PTR_W-1:0] fetch_idx,
  input logic [7:0]       desc_bytes,
  input logic             eng_done,
  input logic [31:0]      done_status,
  input logic             halted,
  input logic             rel_err
);
  AST_NO_FETCH_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !fetch_valid); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && fetch_ready) |=> $stable(fetch_idx)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err); // R7
  AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_done && !(wr_en && wr_sel == 3'd4)) |=> $stable(done_status[14:0])); // R5
  AST_RPTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd4) |=> $stable(done_status[29:16])); // R6
  AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    desc_bytes == 8'd32 || desc_bytes == 8'd128); // R8
endmodule

bind desc_ring_tracker desc_ring_tracker_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_idx(fetch_idx),
  .desc_bytes(desc_bytes), .eng_done(eng_done), .done_status(done_status),
  .halted(halted), .rel_err(rel_err));

// File: tb/desc_ring_tracker_bench.sv
module desc_ring_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        fetch_ready = 1'b0;
  logic        eng_done = 1'b0;
  logic        fetch_valid, halted, rel_err;
  logic [13:0] fetch_idx;
  logic [7:0]  desc_bytes;
  logic [31:0] done_status;

  always #10 clk = ~clk;

  desc_ring_tracker u_desc_ring_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_idx(fetch_idx),
    .desc_bytes(desc_bytes), .eng_done(eng_done), .done_status(done_status),
    .halted(halted), .rel_err(rel_err));

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  int qs, big, halt, posted, infl, pend, fptr, rptr, err;

  always @(posedge clk) begin
    if (!rst_n) begin
      qs = 16; big = 0; halt = 1; posted = 0; infl = 0; pend = 0;
      fptr = 0; rptr = 0; err = 0;
    end else begin
      int eff, lim, d, take, fin, r, s;
      lim  = big ? 4096 : 16384;
      eff  = (qs > lim) ? lim : qs;
      d    = wr_data[14:0];
      take = (!halt && posted > 0 && fetch_ready) ? 1 : 0;
      fin  = (eng_done && infl > 0) ? 1 : 0;
      r    = 0;
      if (wr_en) begin
        case (wr_sel)
          3'd0: if (wr_data >= 1 && wr_data <= lim) qs = wr_data;
          3'd1: begin if (wr_data == 1) big = 0; if (wr_data == 7) big = 1; end
          3'd2: halt = wr_data[0];
          3'd3: posted += d;
          3'd4: begin if (d > pend) begin err = 1; r = pend; end else r = d; end
          default: ;
        endcase
      end
      s = rptr + r;
      rptr = (s >= eff) ? s - eff : s;
      pend = pend + fin - r;
      infl = infl + take - fin;
      posted -= take;
      if (take) fptr = (fptr + 1 >= eff) ? 0 : fptr + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R5 pending", done_status[14:0], pend);
    chk("R6 read index", done_status[29:16], rptr);
    chk("R2/R3 fetch_valid", fetch_valid, (!halt && posted > 0) ? 1 : 0);
    chk("R4/R9 fetch_idx", fetch_idx, fptr);
    chk("R7 rel_err", rel_err, err);
    chk("R8 desc_bytes", desc_bytes, big ? 128 : 32);
    chk("R3 halted", halted, halt);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [2:0] sel, input int d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 halted", halted, 1);
    chk("R1 fetch_valid", fetch_valid, 0);
    chk("R1 status", done_status, 0);
    chk("R1 bytes", desc_bytes, 32);
    chk("R1 err", rel_err, 0);

    // R3 posts accepted while halted, no fetch offered
    wr(3, 3);
    tick(); tick();
    chk("R3 no fetch while halted", fetch_valid, 0);
    wr(0, 4);
    wr(2, 0);
    chk("R2 fetch offered after run", fetch_valid, 1);
    fetch_ready = 1; tick(); tick(); tick();
    fetch_ready = 0;
    chk("R4 idx after three fetches", fetch_idx, 3);
    eng_done = 1; repeat (4) tick();   // fourth pulse has nothing in flight (R5)
    eng_done = 0;
    chk("R5 pending three", done_status[14:0], 3);

    wr(4, 2);
    chk("R6 read index", done_status[29:16], 2);
    wr(4, 5);                          // R7 over-release
    chk("R7 clamp", done_status[14:0], 0);
    chk("R7 flag", rel_err, 1);
    chk("R6 wrap read index", done_status[29:16], 3);

    // R4 wrap and mixed traffic at ring length 4
    for (int i = 0; i < 80; i++) begin
      wr_en = (i % 5 == 0) || (i % 6 == 3);
      wr_sel = (i % 5 == 0) ? 3'd3 : 3'd4;
      wr_data = (i % 5 == 0) ? 2 : 1;
      fetch_ready = i[0];
      eng_done = (i % 3 == 1);
      tick();
    end
    wr_en = 0; fetch_ready = 0; eng_done = 0;
    fetch_ready = 1; repeat (6) tick(); fetch_ready = 0;
    eng_done = 1; repeat (8) tick(); eng_done = 0;

    // R10 completion and release together
    wr(3, 1);
    fetch_ready = 1; tick(); fetch_ready = 0;
    p = done_status[14:0];
    eng_done = 1; wr(4, 1); eng_done = 0;
    chk("R10 pending unchanged", done_status[14:0], (p > 0) ? p : 1);

    // R8 size select
    wr(1, 7);
    chk("R8 128 bytes", desc_bytes, 128);
    wr(1, 5);
    chk("R8 ignore other value", desc_bytes, 128);
    // R9 oversize and zero lengths ignored; fetch wrap still at 4
    wr(0, 5000);
    wr(0, 0);
    wr(3, 6);
    fetch_ready = 1; repeat (6) tick(); fetch_ready = 0;
    wr(1, 1);
    chk("R8 32 bytes", desc_bytes, 32);
    wr(0, 8);
    wr(3, 5);
    fetch_ready = 1; repeat (5) tick(); fetch_ready = 0;
    wr(2, 1);
    wr(3, 2);
    tick();
    chk("R3 halted again", fetch_valid, 0);
    finish_run();
  end
endmodule